// File: doc/BRIEF.md
# Debug Trace Message Serializer

This block turns complete debug trace messages into a stream of narrow beats on an output port whose data width is set by a parameter to 1, 2, 4 or 8 bits. Each message is accepted whole through a valid/ready handshake. A message carries a 6-bit transfer code, a source identifier that tells apart the on-chip sources sharing the port, and a list of packets. Each packet has its own data, bit length and kind, where the kind is fixed or variable. The block turns the message into one bit stream and sends it beat by beat, least significant bit first.

Fixed packets are packed against each other with no gaps. A variable packet is padded with zeros up to the next port-width boundary, and its last beat is flagged on a 2-bit framing sideband. A packet of length zero, as optional vendor packets may be, adds no bits at all. After the last data beat, the block drives exactly one end-of-message beat. A new message can be accepted during that beat, so messages run back to back with no extra idle beat between them.

Top module: `msg_serializer`

## Requirements
- R1: During and after a synchronous active-high reset with no message offered, the framing output is 2'b11, the data output is zero and `in_ready` is 1.
- R2: The first bits sent are the 6-bit transfer code, least significant bit first, and the source identifier follows straight after it with no padding.
- R3: Fixed packets are sent least significant bit first and packed back to back with the preceding bits; their last beat carries no framing marker.
- R4: A variable packet of non-zero length is padded with zero bits up to the next port-width boundary, and its last beat carries framing code 2'b01. When it already ends on a boundary, no extra beat is added.
- R5: A packet whose length is zero contributes no bits and no beats, whether it is fixed or variable.
- R6: After the last data beat of a message, exactly one beat with framing 2'b11 and zero data follows. The output stays at 2'b11 until a message is accepted.
- R7: `in_ready` is 0 during every data beat and 1 during every 2'b11 beat. A message accepted during an end-of-message beat has its first data beat on the very next cycle.
- R8: Framing code 2'b10 is never driven.
- R9: Packet data bits at or above the packet's stated length are never sent; the bits of a last partial beat above the stream's end are zero.
- R10: Every data beat that does not end a variable packet carries framing code 2'b00, so a message start shows as a change from 2'b11 to 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message is offered |
| in_ready | output | 1 | The block accepts a message this cycle |
| in_tcode | input | 6 | Transfer code |
| in_src | input | SRC_W | Source identifier |
| in_pkt_data | input | NPKT*PKT_W | Packet data, packet p at bits [p*PKT_W +: PKT_W] |
| in_pkt_len | input | NPKT*LEN_W | Packet bit length (0..PKT_W), packet p at [p*LEN_W +: LEN_W] |
| in_pkt_var | input | NPKT | Bit p set: packet p is variable-size |
| out_data | output | PORT_W | Beat data, lowest stream bit in bit 0 |
| out_frame | output | 2 | Framing: 00 data, 01 end of variable packet, 11 end of message or idle |

## Verification
The bench aims at the places where the bit pointer can drift. One is a variable packet that ends exactly on a port boundary; a design that pads anyway would insert an empty beat. Another is zero-length packets placed between real ones; a design that mishandles them would emit stray 01 markers or shift the bits that follow. A further case has data bits set above each packet's length, which a missing mask would leak into the stream. Back-to-back messages check that the second message starts on the cycle right after the single 11 beat; a design that added an idle cycle or dropped the end beat would show a mismatch in the beat sequence.

// File: rtl/msg_serializer_pkg.sv
package msg_serializer_pkg;

    localparam int TCODE_W = 6;

    typedef enum logic [1:0] {
        FRM_DATA   = 2'b00,
        FRM_PKTEND = 2'b01,
        FRM_IDLE   = 2'b11
    } frame_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_EOM  = 2'd2
    } ser_state_e;

    function automatic int ceil_div(input int v, input int m);
        return (v + m - 1) / m;
    endfunction

    function automatic int stream_beats(input int src_w, input int npkt,
                                        input int pkt_w, input int port_w);
        return ceil_div(TCODE_W + src_w + npkt * (pkt_w + port_w - 1), port_w);
    endfunction

endpackage

// File: rtl/msg_frame_packer.sv
module msg_frame_packer
    import msg_serializer_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int NPKT   = 3,
    parameter int PKT_W  = 16,
    parameter int PORT_W = 4,
    parameter int LEN_W  = $clog2(PKT_W + 1),
    parameter int NBEATS = stream_beats(SRC_W, NPKT, PKT_W, PORT_W),
    parameter int CNT_W  = $clog2(NBEATS + 1),
    parameter int FRAME_W = NBEATS * PORT_W
) (
    input  logic [TCODE_W-1:0]    tcode,
    input  logic [SRC_W-1:0]      src,
    input  logic [NPKT*PKT_W-1:0] pkt_data,
    input  logic [NPKT*LEN_W-1:0] pkt_len,
    input  logic [NPKT-1:0]       pkt_var,
    output logic [FRAME_W-1:0]    frame,
    output logic [NBEATS-1:0]     end_mask,
    output logic [CNT_W-1:0]      beats
);

    typedef struct packed {
        logic             is_var;
        logic [LEN_W-1:0] len;
        logic [PKT_W-1:0] data;
    } pkt_t;

    pkt_t pkts [NPKT];

    for (genvar p = 0; p < NPKT; p++) begin : g_unpack
        assign pkts[p] = '{is_var: pkt_var[p],
                           len:    pkt_len[p*LEN_W +: LEN_W],
                           data:   pkt_data[p*PKT_W +: PKT_W]};
    end

    always_comb begin
        int               pos;
        int               len;
        logic [PKT_W-1:0] keep;
        frame    = '0;
        end_mask = '0;
        frame[TCODE_W-1:0] = tcode;
        frame    = frame | (FRAME_W'(src) << TCODE_W);
        pos      = TCODE_W + SRC_W;
        for (int p = 0; p < NPKT; p++) begin
            len  = (int'(pkts[p].len) > PKT_W) ? PKT_W : int'(pkts[p].len);
            keep = (len == 0) ? '0 : ({PKT_W{1'b1}} >> (PKT_W - len));
            frame = frame | (FRAME_W'(pkts[p].data & keep) << pos);
            pos   = pos + len;
            if (pkts[p].is_var && len != 0) begin
                pos      = ceil_div(pos, PORT_W) * PORT_W;
                end_mask = end_mask | (NBEATS'(1) << (pos / PORT_W - 1));
            end
        end
        beats = CNT_W'(ceil_div(pos, PORT_W));
    end

endmodule

// File: rtl/msg_beat_shifter.sv
module msg_beat_shifter
    import msg_serializer_pkg::*;
#(
    parameter int PORT_W  = 4,
    parameter int NBEATS  = 8,
    parameter int CNT_W   = $clog2(NBEATS + 1),
    parameter int FRAME_W = NBEATS * PORT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [NBEATS-1:0]  end_mask,
    input  logic [CNT_W-1:0]   beats,
    output logic               busy,
    output logic [PORT_W-1:0]  beat_data,
    output logic [1:0]         beat_frame
);

    ser_state_e          state;
    logic [FRAME_W-1:0]  shreg;
    logic [NBEATS-1:0]   marks;
    logic [CNT_W-1:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            marks <= '0;
            left  <= '0;
        end else begin
            case (state)
                ST_BEAT: begin
                    shreg <= shreg >> PORT_W;
                    marks <= marks >> 1;
                    left  <= left - 1'b1;
                    if (left == CNT_W'(1)) state <= ST_EOM;
                end
                default: begin
                    if (load) begin
                        state <= ST_BEAT;
                        shreg <= frame;
                        marks <= end_mask;
                        left  <= beats;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy       = (state == ST_BEAT);
    assign beat_data  = busy ? shreg[PORT_W-1:0] : '0;
    assign beat_frame = !busy    ? FRM_IDLE   :
                        marks[0] ? FRM_PKTEND : FRM_DATA;

endmodule

// File: rtl/msg_serializer.sv
module msg_serializer
    import msg_serializer_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int NPKT   = 3,
    parameter int PKT_W  = 16,
    parameter int PORT_W = 4,
    parameter int LEN_W  = $clog2(PKT_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [TCODE_W-1:0]    in_tcode,
    input  logic [SRC_W-1:0]      in_src,
    input  logic [NPKT*PKT_W-1:0] in_pkt_data,
    input  logic [NPKT*LEN_W-1:0] in_pkt_len,
    input  logic [NPKT-1:0]       in_pkt_var,
    output logic [PORT_W-1:0]     out_data,
    output logic [1:0]            out_frame
);

    localparam int NBEATS  = stream_beats(SRC_W, NPKT, PKT_W, PORT_W);
    localparam int CNT_W   = $clog2(NBEATS + 1);
    localparam int FRAME_W = NBEATS * PORT_W;

    logic [FRAME_W-1:0] frame;
    logic [NBEATS-1:0]  end_mask;
    logic [CNT_W-1:0]   beats;
    logic               busy;

    msg_frame_packer #(
        .SRC_W(SRC_W), .NPKT(NPKT), .PKT_W(PKT_W), .PORT_W(PORT_W),
        .LEN_W(LEN_W), .NBEATS(NBEATS), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
    ) u_packer (
        .tcode    (in_tcode),
        .src      (in_src),
        .pkt_data (in_pkt_data),
        .pkt_len  (in_pkt_len),
        .pkt_var  (in_pkt_var),
        .frame    (frame),
        .end_mask (end_mask),
        .beats    (beats)
    );

    msg_beat_shifter #(
        .PORT_W(PORT_W), .NBEATS(NBEATS), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (in_valid && in_ready),
        .frame      (frame),
        .end_mask   (end_mask),
        .beats      (beats),
        .busy       (busy),
        .beat_data  (out_data),
        .beat_frame (out_frame)
    );

    assign in_ready = !busy;

endmodule

// File: rtl/msg_serializer_chk.sv
module msg_serializer_chk
    import msg_serializer_pkg::*;
#(
    parameter int SRC_W  = 4,
    parameter int NPKT   = 3,
    parameter int PKT_W  = 16,
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PORT_W-1:0] out_data,
    input logic [1:0]        out_frame
);

    localparam int MAX_BEATS = stream_beats(SRC_W, NPKT, PKT_W, PORT_W);

    int run_len;

    always_ff @(posedge clk) begin
        if (rst || out_frame == 2'b11) run_len <= 0;
        else                           run_len <= run_len + 1;
    end

    AST_NEVER_CODE_10: assert property (@(posedge clk) disable iff (rst)
        out_frame != 2'b10);                                              // R8

    AST_READY_LOW_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_frame != 2'b11) |-> !in_ready);                              // R7

    AST_ACCEPT_STARTS_DATA: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_frame != 2'b11));                 // R7

    AST_END_BEAT_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_frame == 2'b11) |-> (out_data == '0));                       // R6

    AST_NO_UNREQUESTED_START: assert property (@(posedge clk) disable iff (rst)
        (out_frame == 2'b11 && !(in_valid && in_ready)) |=> (out_frame == 2'b11)); // R6

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_len <= MAX_BEATS);                                            // R6

endmodule

bind msg_serializer msg_serializer_chk #(
    .SRC_W(SRC_W), .NPKT(NPKT), .PKT_W(PKT_W), .PORT_W(PORT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_frame (out_frame)
);

// File: tb/sim_msg_serializer.sv
`timescale 1ns/1ps
module sim_msg_serializer;

    localparam int SW = 4;
    localparam int NP = 3;
    localparam int PK = 16;
    localparam int PW = 4;
    localparam int LW = $clog2(PK + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [5:0]        in_tcode = '0;
    logic [SW-1:0]     in_src = '0;
    logic [NP*PK-1:0]  in_pkt_data = '0;
    logic [NP*LW-1:0]  in_pkt_len = '0;
    logic [NP-1:0]     in_pkt_var = '0;
    logic [PW-1:0]     out_data;
    logic [1:0]        out_frame;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0]    m_tc;
    logic [SW-1:0] m_src;
    logic [PK-1:0] m_d [NP];
    int            m_len [NP];
    bit            m_var [NP];

    logic [PW-1:0] exp_d [$];
    logic [1:0]    exp_m [$];

    always #2 clk = ~clk;

    msg_serializer #(.SRC_W(SW), .NPKT(NP), .PKT_W(PK), .PORT_W(PW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tcode(in_tcode), .in_src(in_src), .in_pkt_data(in_pkt_data),
        .in_pkt_len(in_pkt_len), .in_pkt_var(in_pkt_var),
        .out_data(out_data), .out_frame(out_frame)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_msg(input logic [5:0] tc, input logic [SW-1:0] s,
                           input logic [PK-1:0] d0, input int l0, input bit v0,
                           input logic [PK-1:0] d1, input int l1, input bit v1,
                           input logic [PK-1:0] d2, input int l2, input bit v2);
        m_tc = tc; m_src = s;
        m_d[0] = d0; m_len[0] = l0; m_var[0] = v0;
        m_d[1] = d1; m_len[1] = l1; m_var[1] = v1;
        m_d[2] = d2; m_len[2] = l2; m_var[2] = v2;
    endtask

    function automatic void build_exp();
        bit q [$];
        int ends [$];
        exp_d.delete();
        exp_m.delete();
        for (int i = 0; i < 6; i++)  q.push_back(m_tc[i]);
        for (int i = 0; i < SW; i++) q.push_back(m_src[i]);
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < m_len[p]; i++) q.push_back(m_d[p][i]);
            if (m_var[p] && m_len[p] > 0) begin
                while (q.size() % PW != 0) q.push_back(1'b0);
                ends.push_back(q.size() / PW - 1);
            end
        end
        while (q.size() % PW != 0) q.push_back(1'b0);
        for (int b = 0; b < q.size() / PW; b++) begin
            logic [PW-1:0] d;
            logic [1:0]    m;
            for (int i = 0; i < PW; i++) d[i] = q[b*PW + i];
            m = 2'b00;
            foreach (ends[k]) if (ends[k] == b) m = 2'b01;
            exp_d.push_back(d);
            exp_m.push_back(m);
        end
    endfunction

    // Called at a negedge: drive the message and let the next posedge take it.
    task automatic offer();
        in_tcode = m_tc;
        in_src   = m_src;
        for (int p = 0; p < NP; p++) begin
            in_pkt_data[p*PK +: PK] = m_d[p];
            in_pkt_len[p*LW +: LW]  = LW'(m_len[p]);
            in_pkt_var[p]           = m_var[p];
        end
        in_valid = 1'b1;
        chk("R7", "ready when offering", 32'(in_ready), 32'd1);
        @(posedge clk);
    endtask

    // Starts right after the accepting edge; returns at the negedge of the end beat.
    task automatic expect_stream(input string req);
        build_exp();
        for (int b = 0; b < exp_d.size(); b++) begin
            @(negedge clk);
            if (b == 0) in_valid = 1'b0;
            chk(req, $sformatf("beat %0d data", b), 32'(out_data), 32'(exp_d[b]));
            chk(req, $sformatf("beat %0d frame", b), 32'(out_frame), 32'(exp_m[b]));
            chk("R7", $sformatf("beat %0d ready", b), 32'(in_ready), 32'd0);
        end
        @(negedge clk);
        chk("R6", "end beat frame", 32'(out_frame), 32'h3);
        chk("R6", "end beat data", 32'(out_data), 32'h0);
        chk("R7", "end beat ready", 32'(in_ready), 32'd1);
    endtask

    task automatic idle_for(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, "idle frame", 32'(out_frame), 32'h3);
            chk(req, "idle data", 32'(out_data), 32'h0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "frame in reset", 32'(out_frame), 32'h3);
        chk("R1", "data in reset", 32'(out_data), 32'h0);
        rst = 1'b0;
        idle_for(3, "R1");
        chk("R1", "ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic t_fixed_only();
        // R2 R3 R10: 18 bits -> 5 beats, all 00
        set_msg(6'h2D, 4'hA, 16'h0005, 3, 0, 16'h0013, 5, 0, 16'h0000, 0, 0);
        offer();
        expect_stream("R2 R3 R10");
        idle_for(2, "R6");
    endtask

    task automatic t_variable();
        // R4: padded variable ends at beats 3 and 5
        set_msg(6'h05, 4'h3, 16'h0015, 5, 1, 16'h0009, 4, 0, 16'h0001, 1, 1);
        offer();
        expect_stream("R4");
        @(negedge clk);
    endtask

    task automatic t_var_exact();
        // R4: 10 + 6 bits end exactly on a boundary, no extra beat
        set_msg(6'h3F, 4'h0, 16'h002A, 6, 1, 16'h0000, 0, 0, 16'h0000, 0, 0);
        offer();
        expect_stream("R4");
        @(negedge clk);
    endtask

    task automatic t_zero_len();
        // R5: zero-length variable and fixed packets add nothing
        set_msg(6'h11, 4'h6, 16'hFFFF, 0, 1, 16'hFFFF, 0, 0, 16'h0002, 2, 1);
        offer();
        expect_stream("R5");
        @(negedge clk);
    endtask

    task automatic t_mask();
        // R9: data above each length must not appear
        set_msg(6'h01, 4'hF, 16'hFFFF, 3, 0, 16'hFFFF, 7, 1, 16'hFFFF, 1, 0);
        offer();
        expect_stream("R9");
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        // R7: second message starts on the cycle after the single end beat
        set_msg(6'h22, 4'h5, 16'h00A5, 8, 1, 16'h0003, 2, 0, 16'h0000, 0, 0);
        offer();
        expect_stream("R7");
        set_msg(6'h0C, 4'h9, 16'h1234, 16, 0, 16'h0001, 3, 1, 16'h7FFF, 15, 1);
        offer();
        expect_stream("R7");
        set_msg(6'h3A, 4'h1, 16'hBEEF, 16, 1, 16'hCAFE, 16, 1, 16'hF00D, 16, 1);
        offer();
        expect_stream("R4 R7");
        idle_for(3, "R6");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_fixed_only();
        t_variable();
        t_var_exact();
        t_zero_len();
        t_mask();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule